// File: doc/BRIEF.md
# DMA Channel Address Register Bank

This block holds the source and destination byte addresses of a four-channel DMA controller and serves them on a small memory-mapped register bus. The source address is the one the transfer engine reads from, and the destination address is the one it writes to. Each channel has one register of each kind, and the channels repeat every 16 bytes inside the block's own offset space. A request is answered one cycle later with an error flag and read data.

Each stored address is checked on its upper twelve bits against four permitted memory regions. The block does not reject a disallowed address when it is written. Instead, when software pulses a channel's start input, the block raises a sticky configuration-error flag for that channel if either of its addresses falls outside the permitted regions. The flag stays set until that channel's clear pulse.

The destination register accepts only full-word writes. A narrower write gets an error response and does not change the register. The source register accepts byte and halfword writes on their own lanes.

Top module: `dma_addr_bank`

## Requirements
- R1: After reset every source and destination register reads as 0x0000_0000, every configuration-error flag is 0, and no response is pending.
- R2: A request accepted on a clock edge gets exactly one response, with rsp_valid high in the following cycle. The source register of channel i sits at offset 0x100+16*i and the destination register at 0x104+16*i. A full-word write to either register followed by a read returns the written value, and write responses carry zero data.
- R3: A write of size byte (code 0) or halfword (code 1) to a destination register returns rsp_err=1 and leaves that register unchanged.
- R4: A byte write to a source register replaces only byte lane offset[1:0], taken from bus_wdata bits [8*lane+7:8*lane]. A halfword write replaces lanes 3:2 when offset[1] is 1 and lanes 1:0 otherwise. Neither returns an error.
- R5: Size code 3 is reserved. Any access with it to a source or destination register returns rsp_err=1 and zero read data, and changes no register.
- R6: A source register keeps and reads back any full-word value, including one whose upper field is not permitted.
- R7: An address is valid exactly when its bits 31:20 equal 0x000, 0x1FF, 0x200 or 0x400.
- R8: A start pulse on channel i while that channel's source or destination address is invalid sets cfg_err[i] in the next cycle and leaves the other channels' flags as they were.
- R9: cfg_err[i] is sticky. A start with both addresses valid leaves it unchanged, a clear pulse on cfg_clr[i] resets it, and when a clear and an invalid start arrive together the flag ends up set.
- R10: An access to any offset outside the eight channel registers returns zero data and no error, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 12 | Byte offset within the block |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, lane-aligned |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access error for this response |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| chan_start | input | 4 | Per-channel start pulse |
| cfg_clr | input | 4 | Per-channel clear pulse for the configuration error |
| cfg_err | output | 4 | Sticky per-channel configuration error |

## Verification
The assertions check the following on every cycle:
- one response per request, one cycle later;
- an error response, with the register held, after each narrow destination write;
- zero data and no error at undecoded offsets;
- the set, hold and clear behaviour of each channel's configuration flag, given the validity signals that the region comparators drive.

Only the bench's scenarios can show the rest:
- the offset map;
- the byte and halfword lane merging into source registers;
- the round-trip of disallowed source values;
- the exact boundaries of the four permitted regions, including prefixes just next to an allowed one.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bus_size_e;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned REGION_W = 12;
  localparam int unsigned N_REGION = 4;

  // permitted upper-field prefixes, entry k at bits [12k +: 12]
  localparam logic [N_REGION*REGION_W-1:0] REGION_LIST =
    {12'h400, 12'h200, 12'h1FF, 12'h000};

  function automatic logic region_ok(input logic [ADDR_W-1:0] addr);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N_REGION; k++) begin
      if (addr[ADDR_W-1 -: REGION_W] == REGION_LIST[k*REGION_W +: REGION_W])
        hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic [3:0] lane_enables(input bus_size_e sz,
                                              input logic [1:0] lane);
    logic [3:0] be;
    case (sz)
      SZ_BYTE: be = 4'b0001 << lane;
      SZ_HALF: be = lane[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
    return be;
  endfunction

  function automatic logic [ADDR_W-1:0] lane_merge(input logic [ADDR_W-1:0] old_v,
                                                   input logic [ADDR_W-1:0] new_v,
                                                   input bus_size_e sz,
                                                   input logic [1:0] lane);
    logic [3:0]        be;
    logic [ADDR_W-1:0] res;
    be = lane_enables(sz, lane);
    for (int k = 0; k < 4; k++) begin
      res[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode #(
  parameter int unsigned          OFF_W    = 12,
  parameter int unsigned          N_CH     = 4,
  parameter int unsigned          STRIDE   = 16,
  parameter logic [OFF_W-1:0]     BASE_OFF = 12'h100,
  localparam int unsigned         CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [OFF_W-1:0] off,
  output logic             hit_src,
  output logic             hit_dst,
  output logic [CH_W-1:0]  ch_idx,
  output logic [1:0]       lane
);

  localparam int unsigned     STRIDE_LG = $clog2(STRIDE);
  localparam logic [OFF_W-1:0] WIN_LEN  = OFF_W'(N_CH * STRIDE);

  logic [OFF_W-1:0]     rel;
  logic                 in_win;
  logic [STRIDE_LG-1:0] slot;
  logic [STRIDE_LG-1:0] slot_word;

  always_comb begin
    rel       = off - BASE_OFF;
    in_win    = (off >= BASE_OFF) && (rel < WIN_LEN);
    slot      = rel[STRIDE_LG-1:0];
    slot_word = slot >> 2;
    ch_idx    = CH_W'(rel >> STRIDE_LG);
    lane      = slot[1:0];
    hit_src   = in_win && (slot_word == '0);
    hit_dst   = in_win && (slot_word == STRIDE_LG'(1));
  end

endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic [ADDR_W-1:0] wdata,
  input  bus_size_e         sz,
  input  logic [1:0]        lane,
  input  logic              start,
  input  logic              clr,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic              src_ok,
  output logic              dst_ok,
  output logic              cfg_err
);

  logic start_bad;

  assign src_ok    = region_ok(src_q);
  assign dst_ok    = region_ok(dst_q);
  assign start_bad = start && !(src_ok && dst_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else begin
      if (wr_src) src_q <= lane_merge(src_q, wdata, sz, lane);
      if (wr_dst) dst_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_err <= 1'b0;
    else if (start_bad) cfg_err <= 1'b1;
    else if (clr)       cfg_err <= 1'b0;
  end

endmodule

// File: rtl/dma_addr_bank.sv
module dma_addr_bank
  import dma_addr_pkg::*;
#(
  parameter int unsigned      N_CH     = 4,
  parameter int unsigned      OFF_W    = 12,
  parameter int unsigned      STRIDE   = 16,
  parameter logic [OFF_W-1:0] BASE_OFF = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rsp_rdata,
  input  logic [N_CH-1:0]   chan_start,
  input  logic [N_CH-1:0]   cfg_clr,
  output logic [N_CH-1:0]   cfg_err
);

  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  bus_size_e         sz;
  logic              hit_src, hit_dst, hit_any;
  logic [CH_W-1:0]   ch_idx;
  logic [1:0]        lane;
  logic              acc_rsvd, dst_narrow, acc_err, wr_ok, rd_ok;
  logic [ADDR_W-1:0] rd_sel;
  logic [ADDR_W-1:0] src_q [N_CH];
  logic [ADDR_W-1:0] dst_q [N_CH];
  logic [N_CH-1:0]   src_ok, dst_ok;
  logic [N_CH*ADDR_W-1:0] dst_flat;

  assign sz = bus_size_e'(bus_size);

  dma_addr_decode #(
    .OFF_W(OFF_W), .N_CH(N_CH), .STRIDE(STRIDE), .BASE_OFF(BASE_OFF)
  ) u_dec (
    .off(bus_off), .hit_src(hit_src), .hit_dst(hit_dst),
    .ch_idx(ch_idx), .lane(lane)
  );

  // access legality
  assign hit_any    = hit_src || hit_dst;
  assign acc_rsvd   = bus_req && hit_any && (sz == SZ_RSVD);
  assign dst_narrow = bus_req && bus_wr && hit_dst && (sz != SZ_WORD);
  assign acc_err    = acc_rsvd || dst_narrow;
  assign wr_ok      = bus_req && bus_wr && hit_any && !acc_err;
  assign rd_ok      = bus_req && !bus_wr && hit_any && !acc_err;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic sel;
    assign sel = (ch_idx == CH_W'(i));

    dma_addr_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_src (wr_ok && hit_src && sel),
      .wr_dst (wr_ok && hit_dst && sel),
      .wdata  (bus_wdata),
      .sz     (sz),
      .lane   (lane),
      .start  (chan_start[i]),
      .clr    (cfg_clr[i]),
      .src_q  (src_q[i]),
      .dst_q  (dst_q[i]),
      .src_ok (src_ok[i]),
      .dst_ok (dst_ok[i]),
      .cfg_err(cfg_err[i])
    );

    assign dst_flat[i*ADDR_W +: ADDR_W] = dst_q[i];
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_idx == CH_W'(i)) rd_sel = hit_src ? src_q[i] : dst_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_req;
      rsp_err   <= acc_err;
      rsp_rdata <= rd_ok ? rd_sel : '0;
    end
  end

endmodule

// File: rtl/dma_addr_bank_chk.sv
module dma_addr_bank_chk #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   hit_src,
  input logic                   hit_dst,
  input logic                   dst_narrow,
  input logic                   rsp_valid,
  input logic                   rsp_err,
  input logic [ADDR_W-1:0]      rsp_rdata,
  input logic [N_CH-1:0]        chan_start,
  input logic [N_CH-1:0]        cfg_clr,
  input logic [N_CH-1:0]        cfg_err,
  input logic [N_CH-1:0]        src_ok,
  input logic [N_CH-1:0]        dst_ok,
  input logic [N_CH*ADDR_W-1:0] dst_flat
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !rsp_valid); // R2
  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R2
  AST_DST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    dst_narrow |=> rsp_err); // R3
  AST_DST_NARROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    dst_narrow |=> $stable(dst_flat)); // R3
  AST_UNDEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !hit_src && !hit_dst) |=> (!rsp_err && rsp_rdata == '0)); // R10

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    AST_CFG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_start[i] && !(src_ok[i] && dst_ok[i])) |=> cfg_err[i]); // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_start[i] && src_ok[i] && dst_ok[i] && !cfg_clr[i]) |=> $stable(cfg_err[i])); // R9
    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clr[i] && !(chan_start[i] && !(src_ok[i] && dst_ok[i]))) |=> !cfg_err[i]); // R9
  end

endmodule

bind dma_addr_bank dma_addr_bank_chk #(.N_CH(N_CH), .ADDR_W(32)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
  .hit_src(hit_src), .hit_dst(hit_dst), .dst_narrow(dst_narrow),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .chan_start(chan_start), .cfg_clr(cfg_clr), .cfg_err(cfg_err),
  .src_ok(src_ok), .dst_ok(dst_ok), .dst_flat(dst_flat)
);

// File: tb/test_dma_addr_bank.sv
module test_dma_addr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_off = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  chan_start = '0;
  logic [3:0]  cfg_clr = '0;
  logic [3:0]  cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [31:0] src_m [4];
  logic [31:0] dst_m [4];
  logic [3:0]  cfg_m;

  always #5 clk = ~clk;

  dma_addr_bank i_dma_addr_bank (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .chan_start(chan_start), .cfg_clr(cfg_clr), .cfg_err(cfg_err)
  );

  // R7 restated: permitted upper fields
  function automatic logic valid_addr(input logic [31:0] a);
    return a[31:20] inside {12'h000, 12'h1FF, 12'h200, 12'h400};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: pops expected items as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response: actual err=%0b data=%h expected none",
                 rsp_err, rsp_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rsp_err !== e.err || rsp_rdata !== e.rdata) begin
          n_fail++;
          $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
                   e.tag, rsp_err, rsp_rdata, e.err, e.rdata);
        end
      end
    end
  end

  task automatic drive(input logic wr, input logic [11:0] off, input logic [1:0] sz,
                       input logic [31:0] wd);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_wr = wr; bus_off = off; bus_size = sz; bus_wdata = wd;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: bench-side decode, model update, expectation push
  task automatic bus_op(input logic wr, input logic [11:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    int   ch, slot;
    logic is_src, is_dst;
    e.rdata = '0; e.err = 1'b0; e.tag = tag;
    is_src = 1'b0; is_dst = 1'b0; ch = 0; slot = 0;
    if (off >= 12'h100 && off < 12'h140) begin
      ch   = (int'(off) - 'h100) / 16;
      slot = int'(off) % 16;
      is_src = slot < 4;
      is_dst = slot >= 4 && slot < 8;
    end
    if (is_src || is_dst) begin
      if (sz == 2'd3) e.err = 1'b1;
      else if (wr && is_dst && sz != 2'd2) e.err = 1'b1;
      else if (wr && is_dst) dst_m[ch] = wd;
      else if (wr) begin
        if (sz == 2'd2) src_m[ch] = wd;
        else if (sz == 2'd1) begin
          if (slot % 4 >= 2) src_m[ch][31:16] = wd[31:16];
          else               src_m[ch][15:0]  = wd[15:0];
        end else begin
          for (int b = 0; b < 4; b++)
            if (b == slot % 4) src_m[ch][8*b +: 8] = wd[8*b +: 8];
        end
      end else e.rdata = is_src ? src_m[ch] : dst_m[ch];
    end
    sb_q.push_back(e);
    drive(wr, off, sz, wd);
  endtask

  task automatic read_all(input string tag);
    for (int c = 0; c < 4; c++) begin
      bus_op(1'b0, 12'(12'h100 + 16*c), 2'd2, '0, tag);
      bus_op(1'b0, 12'(12'h104 + 16*c), 2'd2, '0, tag);
    end
  endtask

  task automatic start_chk(input logic [3:0] st, input logic [3:0] cl, input string tag);
    for (int c = 0; c < 4; c++) begin
      if (st[c] && !(valid_addr(src_m[c]) && valid_addr(dst_m[c]))) cfg_m[c] = 1'b1;
      else if (cl[c]) cfg_m[c] = 1'b0;
    end
    @(posedge clk); #1;
    chan_start = st; cfg_clr = cl;
    @(posedge clk); #1;
    chan_start = '0; cfg_clr = '0;
    @(negedge clk);
    n_chk++;
    if (cfg_err !== cfg_m) begin
      n_fail++;
      $display("FAIL %s: actual cfg_err=%b expected %b", tag, cfg_err, cfg_m);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin src_m[c] = '0; dst_m[c] = '0; end
    cfg_m = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (cfg_err !== 4'b0 || rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual cfg_err=%b rsp_valid=%b expected 0000 0", cfg_err, rsp_valid);
    end
    read_all("R1 reset value");

    // R2 word map
    for (int c = 0; c < 4; c++) begin
      bus_op(1'b1, 12'(12'h100 + 16*c), 2'd2, 32'h2000_0100 + c, "R2 src write");
      bus_op(1'b1, 12'(12'h104 + 16*c), 2'd2, 32'h4000_0200 + c, "R2 dst write");
    end
    read_all("R2 word readback");
    start_chk(4'b1111, 4'b0000, "R9 valid start leaves flags");

    // R3 narrow destination writes
    bus_op(1'b1, 12'h114, 2'd0, 32'hFFFF_FFFF, "R3 dst byte write");
    bus_op(1'b1, 12'h116, 2'd1, 32'hFFFF_FFFF, "R3 dst half write");
    bus_op(1'b0, 12'h114, 2'd2, '0, "R3 dst unchanged");

    // R4 source lanes
    bus_op(1'b1, 12'h121, 2'd0, 32'h00AB_CD00, "R4 src byte lane1");
    bus_op(1'b1, 12'h122, 2'd1, 32'h1FF5_0000, "R4 src half upper");
    bus_op(1'b1, 12'h123, 2'd0, 32'h5A00_0000, "R4 src byte lane3");
    bus_op(1'b0, 12'h120, 2'd2, '0, "R4 merged readback");

    // R5 reserved size
    bus_op(1'b1, 12'h100, 2'd3, 32'h1234_5678, "R5 reserved write");
    bus_op(1'b0, 12'h104, 2'd3, '0, "R5 reserved read");
    bus_op(1'b0, 12'h100, 2'd2, '0, "R5 src unchanged");

    // R6 disallowed source value round trip
    bus_op(1'b1, 12'h130, 2'd2, 32'h1234_5678, "R6 bad src write");
    bus_op(1'b0, 12'h130, 2'd2, '0, "R6 bad src readback");
    start_chk(4'b1000, 4'b0000, "R8 invalid src start");
    start_chk(4'b1000, 4'b1000, "R9 set wins over clear");
    start_chk(4'b0000, 4'b1000, "R9 clear");
    start_chk(4'b0001, 4'b0000, "R9 valid start no flag");

    // R7 region edges on channel 0 destination
    bus_op(1'b1, 12'h104, 2'd2, 32'h1FF0_0010, "R7 dst 1FF");
    start_chk(4'b0001, 4'b0000, "R7 1FF valid");
    bus_op(1'b1, 12'h104, 2'd2, 32'h1FEF_FFFF, "R7 dst 1FE");
    start_chk(4'b0001, 4'b0000, "R7 1FE invalid");
    start_chk(4'b0000, 4'b0001, "R9 clear ch0");
    bus_op(1'b1, 12'h104, 2'd2, 32'h0010_0000, "R7 dst 001");
    start_chk(4'b0011, 4'b0000, "R8 only bad channel flags");
    bus_op(1'b1, 12'h104, 2'd2, 32'h000F_FFFF, "R7 dst 000");
    start_chk(4'b0001, 4'b0001, "R7 000 valid then clear");

    // R10 undecoded offsets
    bus_op(1'b1, 12'h108, 2'd2, 32'hDEAD_BEEF, "R10 write gap");
    bus_op(1'b1, 12'h140, 2'd2, 32'hDEAD_BEEF, "R10 write past window");
    bus_op(1'b0, 12'h108, 2'd2, '0, "R10 read gap");
    bus_op(1'b0, 12'h0FC, 2'd0, '0, "R10 read below window");
    bus_op(1'b0, 12'h13C, 2'd3, '0, "R10 reserved size at gap");
    read_all("R10 registers untouched");

    repeat (4) @(posedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", sb_q.size());
    end
    summary();
    $finish;
  end

endmodule